// File: doc/BRIEF.md
# I2C SCL Clock Waveform Generator

This block makes the serial clock of an I2C master. Two inputs set it up: the frequency of the main clock that feeds the block, and the bus frequency that is wanted. From these it first picks a power-of-two pre-divider, so that the module clock does not exceed a ceiling. It then runs a sequential division and searches for a two-level divider. That divider is a 3-bit exponent and an 8-bit count, and each SCL phase lasts `count * 2^exponent + 4` input cycles.

A new setting is worked out only when the requested frequency differs from the last one applied. A request of zero selects the default bus rate. The divider fields are set to zero for one cycle before the new value is loaded. High and low phases always use the same count. Once enabled, the generator drives SCL low or releases it, and it pulses a strobe on the last cycle of each phase. While SCL is released but still sensed low, the phase count holds, so a target can stretch the clock.

Top module: `scl_clock_gen`

## Requirements
- R1: `pre_sel` is the smallest k in 0..3 with `mck_hz >> k <= 66_000_000`, or 3 when no k fits. The module clock is `mck_hz >> pre_sel`.
- R2: A `req_hz` of zero is treated as a request for 100_000 Hz.
- R3: A new computation starts on a clock edge only when the block is idle and the effective request differs from the last one applied. The last applied value is 0 after reset. `busy` is high for exactly 34 cycles after that edge. A request that equals the last one applied leaves `busy` low and the fields unchanged.
- R4: With q = module clock / (2 * effective request), integer division, `ckdiv` is the smallest e in 0..7 with `(q - 4) >> e <= 255`. `cldiv` is then `(q - 4) >> e`.
- R5: `chdiv` always equals `cldiv`.
- R6: On the 33rd edge after a computation starts, all three fields are zero. On the 34th edge they take the new values.
- R7: If q < 4, the result is `ckdiv`=0 and `cldiv`=0. If no exponent fits, the result is `ckdiv`=7 and `cldiv`=255.
- R8: While `gen_en` is high, SCL alternates between phases, starting with a released (high) phase. Each phase lasts `div * 2^ckdiv + 4` cycles, using `chdiv` for the high phase and `cldiv` for the low phase, as set at each edge. `scl_drive_low`=1 means the low phase.
- R9: While `scl_drive_low` is 0 and `scl_sense` is 0, the phase count holds and no phase ends.
- R10: With `gen_en` low, `scl_drive_low` is 0 on the next cycle and the phase count restarts from zero.
- R11: `scl_edge_stb` is high exactly on the last cycle of each phase, and never while the phase is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mck_hz | input | 32 | Main clock frequency in Hz |
| req_hz | input | 32 | Requested bus frequency in Hz, 0 selects default |
| gen_en | input | 1 | Enables SCL generation |
| scl_sense | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| scl_edge_stb | output | 1 | Last cycle of the current phase |
| pre_sel | output | 2 | Pre-divider exponent (divide by 2^pre_sel) |
| ckdiv | output | 3 | Divider exponent |
| cldiv | output | 8 | Low-phase count |
| chdiv | output | 8 | High-phase count |
| busy | output | 1 | Divider computation in progress |

## Verification
`pre_sel` is combinational, so it is due in the same cycle as `mck_hz`. `busy` rises one edge after a differing request is seen. The fields clear 33 edges after that start and load their new values on the 34th. The SCL level and strobe follow the count one register later, and a phase ends `len - 1` edges after it begins. The bench keeps a behavioural model that updates on the same rising edge as the design, from inputs the bench set at the falling edge before. It compares every output at the next falling edge, so each result is checked in the cycle the requirements place it.

// File: rtl/scl_gen_pkg.sv
// Package: shared constants and types for the SCL clock generator.
// Assumes an 8-bit phase count and a 3-bit exponent throughout.
package scl_gen_pkg;
    localparam int CK_W    = 3;
    localparam int DIV_W   = 8;
    localparam int OFFSET  = 4;
    localparam int NUM_EXP = 1 << CK_W;
    localparam int DIV_MAX = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [CK_W-1:0]  ck;
        logic [DIV_W-1:0] lo;
        logic [DIV_W-1:0] hi;
    } scl_cfg_t;

    typedef enum logic [1:0] {
        SOLVE_IDLE,
        SOLVE_DIV,
        SOLVE_CLR,
        SOLVE_LOAD
    } solve_state_t;
endpackage

// File: rtl/scl_predivider.sv
// Pre-divider selector: picks the smallest power-of-two divisor of the main
// clock that brings it to or below MAX_HZ; uses the largest if none fits.
// Purely combinational; assumes mck_hz is quasi-static.
module scl_predivider #(
    parameter int FW     = 32,
    parameter int MAX_HZ = 66_000_000,
    parameter int STEPS  = 4,
    localparam int SEL_W = $clog2(STEPS)
) (
    input  logic [FW-1:0]    mck_hz,
    output logic [SEL_W-1:0] sel,
    output logic [FW-1:0]    mod_hz
);
    // Search from the largest divisor down so the smallest fitting one wins.
    always_comb begin
        sel = SEL_W'(STEPS - 1);
        for (int i = STEPS - 1; i >= 0; i--) begin
            if ((mck_hz >> i) <= FW'(MAX_HZ)) sel = SEL_W'(i);
        end
        mod_hz = mck_hz >> sel;
    end
endmodule

// File: rtl/scl_div_solver.sv
// Divider solver: when the effective request changes, divides the module
// clock by twice the request with a bit-serial restoring divider, then picks
// the smallest exponent whose shifted count fits 8 bits. The fields are
// zeroed for one cycle before the new value is loaded.
// Assumes DEFAULT_HZ is nonzero, so the divisor is never zero.
module scl_div_solver
    import scl_gen_pkg::*;
#(
    parameter int FW         = 32,
    parameter int DEFAULT_HZ = 100_000,
    localparam int STEP_W    = $clog2(FW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] mod_hz,
    input  logic [FW-1:0] req_hz,
    output scl_cfg_t      cfg,
    output logic          busy
);
    solve_state_t      state;
    logic [FW-1:0]     last_hz;
    logic [FW-1:0]     eff_hz;
    logic [FW-1:0]     dvd;
    logic [FW:0]       dvs;
    logic [FW:0]       rem;
    logic [FW-1:0]     quo;
    logic [STEP_W-1:0] step;
    logic [FW+1:0]     trial;
    logic              fits;
    logic [FW-1:0]     sub;
    logic [CK_W-1:0]   pick_ck;
    logic [DIV_W-1:0]  pick_div;

    assign eff_hz = (req_hz == '0) ? FW'(DEFAULT_HZ) : req_hz;
    assign trial  = {rem, dvd[FW-1]};
    assign fits   = trial >= {1'b0, dvs};
    assign busy   = (state != SOLVE_IDLE);

    // Smallest exponent whose shifted count fits; clamp underflow and overflow.
    always_comb begin
        sub      = quo - FW'(OFFSET);
        pick_ck  = CK_W'(NUM_EXP - 1);
        pick_div = DIV_W'(DIV_MAX);
        if (quo < FW'(OFFSET)) begin
            pick_ck  = '0;
            pick_div = '0;
        end else begin
            for (int e = NUM_EXP - 1; e >= 0; e--) begin
                if ((sub >> e) <= FW'(DIV_MAX)) begin
                    pick_ck  = CK_W'(e);
                    pick_div = DIV_W'(sub >> e);
                end
            end
        end
    end

    // Sequencer: start on change, divide, clear the fields, then load them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SOLVE_IDLE;
            last_hz <= '0;
            dvd     <= '0;
            dvs     <= '0;
            rem     <= '0;
            quo     <= '0;
            step    <= '0;
            cfg     <= '0;
        end else begin
            case (state)
                SOLVE_IDLE: if (eff_hz != last_hz) begin
                    last_hz <= eff_hz;
                    dvd     <= mod_hz;
                    dvs     <= {eff_hz, 1'b0};
                    rem     <= '0;
                    quo     <= '0;
                    step    <= '0;
                    state   <= SOLVE_DIV;
                end
                SOLVE_DIV: begin
                    rem  <= fits ? FW'(trial - {1'b0, dvs}) : trial[FW:0];
                    quo  <= {quo[FW-2:0], fits};
                    dvd  <= dvd << 1;
                    step <= step + STEP_W'(1);
                    if (step == STEP_W'(FW - 1)) state <= SOLVE_CLR;
                end
                SOLVE_CLR: begin
                    cfg   <= '0;
                    state <= SOLVE_LOAD;
                end
                default: begin
                    cfg   <= '{ck: pick_ck, lo: pick_div, hi: pick_div};
                    state <= SOLVE_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/scl_phase_gen.sv
// Phase generator: alternates released/low SCL phases, each lasting
// div * 2^ck + OFFSET cycles, starting with a released phase after enable.
// Holds while SCL is released but sensed low (target clock stretching).
module scl_phase_gen
    import scl_gen_pkg::*;
#(
    localparam int LEN_W = DIV_W + NUM_EXP
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     sense,
    input  scl_cfg_t cfg,
    output logic     drive_low,
    output logic     edge_stb
);
    logic             released;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] len;
    logic             hold;
    logic             last;

    assign len       = (LEN_W'(released ? cfg.hi : cfg.lo) << cfg.ck) + LEN_W'(OFFSET);
    assign hold      = released && !sense;
    assign last      = cnt >= len - LEN_W'(1);
    assign edge_stb  = en && last && !hold;
    assign drive_low = !released;

    // Phase counter and SCL level.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            released <= 1'b1;
            cnt      <= '0;
        end else if (!hold) begin
            if (last) begin
                released <= !released;
                cnt      <= '0;
            end else begin
                cnt <= cnt + LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/scl_clock_gen.sv
// Top: SCL clock waveform generator. Combines the pre-divider selector,
// the divider solver and the phase generator.
// Assumes mck_hz and req_hz are synchronous to clk.
module scl_clock_gen
    import scl_gen_pkg::*;
#(
    parameter int FW         = 32,
    parameter int MAX_MOD_HZ = 66_000_000,
    parameter int DEFAULT_HZ = 100_000,
    parameter int PRE_STEPS  = 4,
    localparam int SEL_W     = $clog2(PRE_STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FW-1:0]    mck_hz,
    input  logic [FW-1:0]    req_hz,
    input  logic             gen_en,
    input  logic             scl_sense,
    output logic             scl_drive_low,
    output logic             scl_edge_stb,
    output logic [SEL_W-1:0] pre_sel,
    output logic [CK_W-1:0]  ckdiv,
    output logic [DIV_W-1:0] cldiv,
    output logic [DIV_W-1:0] chdiv,
    output logic             busy
);
    logic [FW-1:0] mod_hz;
    scl_cfg_t      cfg;

    scl_predivider #(.FW(FW), .MAX_HZ(MAX_MOD_HZ), .STEPS(PRE_STEPS)) u_pre (
        .mck_hz (mck_hz),
        .sel    (pre_sel),
        .mod_hz (mod_hz)
    );

    scl_div_solver #(.FW(FW), .DEFAULT_HZ(DEFAULT_HZ)) u_solve (
        .clk    (clk),
        .rst_n  (rst_n),
        .mod_hz (mod_hz),
        .req_hz (req_hz),
        .cfg    (cfg),
        .busy   (busy)
    );

    scl_phase_gen u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (gen_en),
        .sense     (scl_sense),
        .cfg       (cfg),
        .drive_low (scl_drive_low),
        .edge_stb  (scl_edge_stb)
    );

    assign ckdiv = cfg.ck;
    assign cldiv = cfg.lo;
    assign chdiv = cfg.hi;
endmodule

// File: rtl/scl_gen_checker.sv
// Checker: temporal properties of the SCL clock generator ports.
module scl_gen_checker #(
    parameter int FW         = 32,
    parameter int MAX_MOD_HZ = 66_000_000
) (
    input logic          clk,
    input logic          rst_n,
    input logic [FW-1:0] mck_hz,
    input logic          gen_en,
    input logic          scl_sense,
    input logic          scl_drive_low,
    input logic          scl_edge_stb,
    input logic [1:0]    pre_sel,
    input logic [2:0]    ckdiv,
    input logic [7:0]    cldiv,
    input logic [7:0]    chdiv
);
    logic [18:0] fields;
    assign fields = {ckdiv, cldiv, chdiv};

    AST_PRESEL_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_sel != 2'd3) |-> ((mck_hz >> pre_sel) <= FW'(MAX_MOD_HZ))); // R1
    AST_EQUAL_PHASES: assert property (@(posedge clk) disable iff (!rst_n)
        chdiv == cldiv); // R5
    AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (fields != '0 && fields != $past(fields)) |-> ($past(fields) == '0)); // R6
    AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && !scl_drive_low && !scl_sense) |=> !scl_drive_low); // R9
    AST_STRETCH_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_drive_low && !scl_sense) |-> !scl_edge_stb); // R11
    AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> !scl_drive_low); // R10
endmodule

bind scl_clock_gen scl_gen_checker #(.FW(FW), .MAX_MOD_HZ(MAX_MOD_HZ)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mck_hz        (mck_hz),
    .gen_en        (gen_en),
    .scl_sense     (scl_sense),
    .scl_drive_low (scl_drive_low),
    .scl_edge_stb  (scl_edge_stb),
    .pre_sel       (pre_sel),
    .ckdiv         (ckdiv),
    .cldiv         (cldiv),
    .chdiv         (chdiv)
);

// File: tb/tb_scl_clock_gen.sv
// Bench: behavioural reference model stepped on each rising edge and
// compared with every output at each falling edge.
module tb_scl_clock_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mck_hz = 32'd40;
    logic [31:0] req_hz = 32'd0;
    logic        gen_en = 1'b0;
    logic        stretch = 1'b0;
    logic        scl_sense;
    logic        scl_drive_low, scl_edge_stb, busy;
    logic [1:0]  pre_sel;
    logic [2:0]  ckdiv;
    logic [7:0]  cldiv, chdiv;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference model state
    int     m_left = 0;
    longint m_last = 0;
    int     m_ck = 0, m_lo = 0, m_hi = 0, m_nck = 0, m_ndiv = 0;
    bit     m_rel = 1'b1;
    int     m_cnt = 0;

    always #5 clk = ~clk;

    assign scl_sense = ~(scl_drive_low | stretch);

    scl_clock_gen dut (
        .clk(clk), .rst_n(rst_n), .mck_hz(mck_hz), .req_hz(req_hz),
        .gen_en(gen_en), .scl_sense(scl_sense), .scl_drive_low(scl_drive_low),
        .scl_edge_stb(scl_edge_stb), .pre_sel(pre_sel), .ckdiv(ckdiv),
        .cldiv(cldiv), .chdiv(chdiv), .busy(busy)
    );

    function automatic int exp_sel(longint m);
        for (int k = 0; k < 4; k++) if ((m >> k) <= 66_000_000) return k;
        return 3;
    endfunction

    function automatic void exp_solve(longint m, longint f, output int ck, output int dv);
        longint q;
        q  = (m >> exp_sel(m)) / (2 * f);
        ck = 7;
        dv = 255;
        if (q < 4) begin ck = 0; dv = 0; return; end
        for (int e = 0; e < 8; e++) begin
            if (((q - 4) >> e) <= 255) begin ck = e; dv = int'((q - 4) >> e); return; end
        end
    endfunction

    function automatic int m_len();
        return ((m_rel ? m_hi : m_lo) << m_ck) + 4;
    endfunction

    // Model step on the same edge as the design.
    always @(posedge clk) begin
        longint eff;
        eff = (req_hz == 0) ? 100_000 : longint'(req_hz);
        if (!rst_n) begin
            m_left = 0; m_last = 0; m_ck = 0; m_lo = 0; m_hi = 0;
            m_rel = 1'b1; m_cnt = 0;
        end else begin
            if (!gen_en) begin
                m_rel = 1'b1; m_cnt = 0;
            end else if (!(m_rel && stretch)) begin
                if (m_cnt >= m_len() - 1) begin m_rel = !m_rel; m_cnt = 0; end
                else m_cnt++;
            end
            if (m_left > 0) begin
                m_left--;
                if (m_left == 1) begin m_ck = 0; m_lo = 0; m_hi = 0; end
                if (m_left == 0) begin m_ck = m_nck; m_lo = m_ndiv; m_hi = m_ndiv; end
            end else if (eff != m_last) begin
                m_last = eff;
                exp_solve(longint'(mck_hz), eff, m_nck, m_ndiv);
                m_left = 34;
            end
        end
    end

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Compare all outputs against the model at each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            string ctag;
            string ltag;
            bit stb;
            ctag = (m_left == 1 || (m_left == 0 && m_ck == 0 && m_lo == 0 && m_last != 0 && m_nck == 0 && m_ndiv == 0 && 0)) ? "R6" :
                   ((m_ck == 7 && m_lo == 255) || (m_lo == 0 && m_left == 0)) ? "R7" : "R4";
            ltag = stretch ? "R9" : (!gen_en ? "R10" : "R8");
            stb  = gen_en && (m_cnt >= m_len() - 1) && !(m_rel && stretch);
            chk("R1", "pre_sel", pre_sel, exp_sel(longint'(mck_hz)));
            chk("R3", "busy", busy, m_left != 0);
            chk(ctag, "ckdiv", ckdiv, m_ck);
            chk(ctag, "cldiv", cldiv, m_lo);
            chk("R5", "chdiv", chdiv, m_lo);
            chk(ltag, "scl_drive_low", scl_drive_low, !m_rel);
            chk("R11", "scl_edge_stb", scl_edge_stb, stb);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150_000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(3);
        // Reset state
        chk("R3", "busy in reset", busy, 0);
        chk("R4", "cldiv in reset", cldiv, 0);
        chk("R10", "drive_low in reset", scl_drive_low, 0);
        mck_hz = 32'd132_000_000;
        rst_n  = 1'b1;
        run(40);
        // R2: zero request means 100 kHz -> q=330, exponent 1, count 163
        chk("R2", "default cldiv", cldiv, 163);
        chk("R2", "default ckdiv", ckdiv, 1);
        // R3: explicit request equal to last applied -> no recompute
        req_hz = 32'd100_000;
        run(40);
        chk("R3", "no recompute busy", busy, 0);
        // R8/R11: short phases, q=10 -> count 6, len 10
        mck_hz = 32'd40; req_hz = 32'd2;
        run(5);
        req_hz = 32'd3;  // changed while busy; picked up after
        run(80);
        gen_en = 1'b1;
        run(60);
        // R9: stretch during a released phase
        while (scl_drive_low) run(1);
        run(2);
        stretch = 1'b1;
        run(15);
        stretch = 1'b0;
        run(40);
        // R10: disable
        gen_en = 1'b0;
        run(5);
        // R4: exponent 1 case
        mck_hz = 32'd1000; req_hz = 32'd1;
        run(40);
        // R7: saturate (and pre_sel 0 at the 66 MHz boundary)
        mck_hz = 32'd66_000_000; req_hz = 32'd4;
        run(40);
        chk("R7", "saturated ckdiv", ckdiv, 7);
        // R7: underflow, len 4 phases
        mck_hz = 32'd40; req_hz = 32'd10;
        run(40);
        gen_en = 1'b1;
        run(30);
        gen_en = 1'b0;
        // R1: pre-divider cases
        mck_hz = 32'd600_000_000; req_hz = 32'd3_000_000;
        run(40);
        mck_hz = 32'd264_000_000; req_hz = 32'd400_000;
        run(40);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule